// File: doc/BRIEF.md
# FIFO Serial Buffer Core

This block is the buffering and status heart of a FIFO-based UART. Characters written by software queue in a transmit FIFO until a serial shifter takes them one at a time. Characters delivered by a receiver queue in a receive FIFO until software reads them. Each received character carries parity-error, framing-error and break indications. Two programmable thresholds decide when the block asks for more transmit data and when it reports that enough receive data is waiting. A loopback mode feeds the transmit queue straight back into the receive queue, so the data path can be tested without a line.

Software reaches the block through a small register bus with five word addresses. Address 0 is the transmit data write. Address 1 is the receive data read, which also removes the character it returns. Address 2 is the status word, address 3 is the 8-bit FIFO control byte and address 4 is the occupancy word. Reads are combinational. Writes and receive pops take effect on the clock edge. The baud generator and the shifters sit outside the block.

Top module: `serbuf_core`

## Requirements
- R1: During reset and after its release the control byte and both counts are 0. One clock after release the status word reads 0x0020.
- R2: Bytes written to address 0 leave on txq_data in write order. txq_valid is high exactly while the transmit FIFO holds data, and txq_take removes the head byte. A write while 16 bytes are held is dropped.
- R3: Receive pushes are read back from address 1 in arrival order, as {8'h00, byte}. Each such read removes the byte. Address 4 reads {3'b0, transmit count, 3'b0, receive count}.
- R4: Control bits 7:6 choose the receive threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. Status bit 1 sets once the receive count reaches that threshold.
- R5: Control bits 5:4 choose the transmit threshold: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1. Status bit 5 sets once the transmit count is at or below that threshold.
- R6: A status write clears each bit of mask 0x00F3 that is written 0 and keeps each bit written 1. Bits 15:8 and 3:2 ignore writes. If a flag's set condition still holds, the flag stays 1.
- R7: While control bit 2 is 1 the transmit FIFO is held empty. While control bit 1 is 1 the receive FIFO is held empty. Pushes made during that time are dropped.
- R8: With control bit 0 set, each byte taken by txq_take enters the receive FIFO with no error marks, and rxq_push is ignored.
- R9: A push into a full receive FIFO is dropped and sets status bit 7.
- R10: Status bits 15:12 and 11:8 count the held characters marked with a parity error and with a framing error, saturating at 15. Bits 2 and 3 show the parity and framing marks of the head character.
- R11: A push with rxq_brk set raises status bit 4.
- R12: Status bit 6 sets when the transmit FIFO is empty while shift_done is high. It clears on the next accepted transmit write.
- R13: Status bit 0 sets while the receive FIFO holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 1) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| txq_valid | output | 1 | Transmit FIFO holds a byte |
| txq_data | output | 8 | Head byte of the transmit FIFO |
| txq_take | input | 1 | Shifter takes the head byte |
| shift_done | input | 1 | Shifter finished its last stop bit |
| rxq_push | input | 1 | Receiver delivers a character |
| rxq_data | input | 8 | Received character |
| rxq_perr | input | 1 | Character has a parity error |
| rxq_ferr | input | 1 | Character has a framing error |
| rxq_brk | input | 1 | Break seen with this character |

## Verification
The assertions assume that software never reads address 1 in the same cycle as an overflowing push. They also assume that txq_take is raised only while txq_valid is high. The drop rule and the error-count bounds are stated for those conditions. The stimulus issues one bus access, take or push per two clocks. It never combines a receive read with a push, and it takes bytes only after writing them. Every flag check therefore lands after both the count register and the sticky flag register have settled.

// File: rtl/serbuf_pkg.sv
package serbuf_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_TXD  = 3'd0;
   localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
   localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

   // status bits that software may clear by writing zero
   localparam logic [15:0] CLR_MASK = 16'h00F3;

   typedef struct packed {
      logic       perr;
      logic       ferr;
      logic [7:0] data;
   } rx_ent_t;
endpackage

// File: rtl/serbuf_fifo.sv
module serbuf_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] cnt,
   output logic          push_ok,
   output logic          pop_ok,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= din;
   end
endmodule

// File: rtl/serbuf_trig.sv
module serbuf_trig #(
   parameter bit IS_RX = 1'b1,
   parameter int CW    = 5
) (
   input  logic [1:0]    code,
   output logic [CW-1:0] thr
);
   generate
      if (IS_RX) begin : g_rx
         always_comb begin
            unique case (code)
               2'd0: thr = CW'(1);
               2'd1: thr = CW'(4);
               2'd2: thr = CW'(8);
               default: thr = CW'(14);
            endcase
         end
      end else begin : g_tx
         always_comb begin
            unique case (code)
               2'd0: thr = CW'(8);
               2'd1: thr = CW'(4);
               2'd2: thr = CW'(2);
               default: thr = CW'(1);
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/serbuf_core.sv
module serbuf_core
   import serbuf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    bus_addr,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [15:0]   bus_wdata,
   output logic [15:0]   bus_rdata,
   output logic          txq_valid,
   output logic [DW-1:0] txq_data,
   input  logic          txq_take,
   input  logic          shift_done,
   input  logic          rxq_push,
   input  logic [DW-1:0] rxq_data,
   input  logic          rxq_perr,
   input  logic          rxq_ferr,
   input  logic          rxq_brk
);
   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0 || CW > 5 || DW != 8) begin : g_bad
         $error("serbuf_core: DEPTH must be 16 and DW must be 8");
      end
   endgenerate

   logic [7:0]    ctrl_q;
   logic          loop_en, tx_flush, rx_flush;
   logic          tx_wr, rx_rd, st_wr, ct_wr;
   logic [CW-1:0] tx_cnt, rx_cnt, tx_thr, rx_thr;
   logic          tx_push_ok, tx_pop_ok, tx_full, tx_empty;
   logic          rx_push_ok, rx_pop_ok, rx_full, rx_empty;
   logic          rx_push_in;
   rx_ent_t       rx_din, rx_head;
   logic [DW-1:0] tx_head;
   logic [CW-1:0] perr_n, ferr_n;
   logic          er_q, tend_q, tdfe_q, brk_q, rdf_q, dr_q;
   logic [15:0]   keep, status, count_w;

   assign loop_en  = ctrl_q[0];
   assign rx_flush = ctrl_q[1];
   assign tx_flush = ctrl_q[2];

   assign tx_wr = bus_wr && (bus_addr == A_TXD);
   assign st_wr = bus_wr && (bus_addr == A_STAT);
   assign ct_wr = bus_wr && (bus_addr == A_CTRL);
   assign rx_rd = bus_rd && (bus_addr == A_RXD);

   serbuf_fifo #(.W(DW), .DEPTH(DEPTH)) u_txf (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_wr), .din(bus_wdata[DW-1:0]),
      .pop(txq_take), .dout(tx_head), .cnt(tx_cnt),
      .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
      .full(tx_full), .empty(tx_empty)
   );

   // loopback steers popped transmit bytes into the receive side
   always_comb begin
      if (loop_en) begin
         rx_push_in = tx_pop_ok;
         rx_din     = '{perr: 1'b0, ferr: 1'b0, data: tx_head};
      end else begin
         rx_push_in = rxq_push;
         rx_din     = '{perr: rxq_perr, ferr: rxq_ferr, data: rxq_data};
      end
   end

   serbuf_fifo #(.W($bits(rx_ent_t)), .DEPTH(DEPTH)) u_rxf (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_push_in), .din(rx_din),
      .pop(rx_rd), .dout(rx_head), .cnt(rx_cnt),
      .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
      .full(rx_full), .empty(rx_empty)
   );

   serbuf_trig #(.IS_RX(1'b1), .CW(CW)) u_rtrig (.code(ctrl_q[7:6]), .thr(rx_thr));
   serbuf_trig #(.IS_RX(1'b0), .CW(CW)) u_ttrig (.code(ctrl_q[5:4]), .thr(tx_thr));

   assign keep = st_wr ? (bus_wdata | ~CLR_MASK) : 16'hFFFF;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         perr_n <= '0;
         ferr_n <= '0;
         er_q   <= 1'b0;
         tend_q <= 1'b0;
         tdfe_q <= 1'b0;
         brk_q  <= 1'b0;
         rdf_q  <= 1'b0;
         dr_q   <= 1'b0;
      end else begin
         if (ct_wr) ctrl_q <= bus_wdata[7:0];
         if (rx_flush) begin
            perr_n <= '0;
            ferr_n <= '0;
         end else begin
            perr_n <= perr_n + CW'(rx_push_ok && rx_din.perr) - CW'(rx_pop_ok && rx_head.perr);
            ferr_n <= ferr_n + CW'(rx_push_ok && rx_din.ferr) - CW'(rx_pop_ok && rx_head.ferr);
         end
         er_q   <= (er_q && keep[7]) || (rx_push_in && rx_full && !rx_flush);
         brk_q  <= (brk_q && keep[4]) || (!loop_en && rxq_push && rxq_brk && !rx_flush);
         tdfe_q <= (tdfe_q && keep[5]) || (tx_cnt <= tx_thr);
         rdf_q  <= (rdf_q && keep[1]) || (rx_cnt >= rx_thr);
         dr_q   <= (dr_q && keep[0]) || !rx_empty;
         if (tx_push_ok) tend_q <= 1'b0;
         else            tend_q <= (tend_q && keep[6]) || (tx_empty && shift_done);
      end
   end

   function automatic logic [3:0] sat4(input logic [CW-1:0] v);
      return (v > CW'(15)) ? 4'hF : v[3:0];
   endfunction

   assign status  = {sat4(perr_n), sat4(ferr_n), er_q, tend_q, tdfe_q, brk_q,
                     rx_head.ferr && !rx_empty, rx_head.perr && !rx_empty, rdf_q, dr_q};
   assign count_w = {3'b000, 5'(tx_cnt), 3'b000, 5'(rx_cnt)};

   always_comb begin
      unique case (bus_addr)
         A_RXD:   bus_rdata = {8'h00, rx_head.data};
         A_STAT:  bus_rdata = status;
         A_CTRL:  bus_rdata = {8'h00, ctrl_q};
         A_CNT:   bus_rdata = count_w;
         default: bus_rdata = 16'h0000;
      endcase
   end

   assign txq_valid = !tx_empty;
   assign txq_data  = tx_head;
endmodule

// File: rtl/serbuf_chk.sv
module serbuf_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [7:0]    ctrl_q,
   input logic [CW-1:0] tx_cnt,
   input logic [CW-1:0] rx_cnt,
   input logic [CW-1:0] perr_n,
   input logic [CW-1:0] ferr_n,
   input logic [15:0]   status,
   input logic          txq_valid,
   input logic          txq_take,
   input logic          tx_wr,
   input logic          rx_push_in
);
   AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cnt <= CW'(DEPTH)); // R2
   AST_TXQ_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      txq_valid == (tx_cnt != '0)); // R2
   AST_TX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[2] |=> tx_cnt == '0); // R7
   AST_RX_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[1] |=> rx_cnt == '0); // R7
   AST_RX_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push_in && rx_cnt == CW'(DEPTH) && !ctrl_q[1]) |=> status[7]); // R9
   AST_TEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_cnt != CW'(DEPTH) && !ctrl_q[2]) |=> !status[6]); // R12
   AST_ERRCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (perr_n <= rx_cnt) && (ferr_n <= rx_cnt)); // R10
   AST_LOOP_BLOCKS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[0] && !txq_take) |=> rx_cnt <= $past(rx_cnt)); // R8
endmodule

bind serbuf_core serbuf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
   .perr_n(perr_n), .ferr_n(ferr_n), .status(status), .txq_valid(txq_valid),
   .txq_take(txq_take), .tx_wr(tx_wr), .rx_push_in(rx_push_in)
);

// File: tb/serbuf_core_test.sv
module serbuf_core_test;
   localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_PUSH = 3'd2, OP_TAKE = 3'd3, OP_DONE = 3'd4;
   localparam logic [2:0] TXD = 3'd0, RXD = 3'd1, STA = 3'd2, CTL = 3'd3, CNT = 3'd4;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  addr;
      logic [15:0] data;  // push: [7:0] byte, [8] parity, [9] framing, [10] break
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 50;
   localparam vec_t VEC [NV] = '{
      '{OP_RD,   STA, 16'h0000, 16'h0020, 4'd1},  // R1 reset status
      '{OP_RD,   CNT, 16'h0000, 16'h0000, 4'd1},  // R1 counts zero
      '{OP_WR,   CTL, 16'h0040, 16'h0000, 4'd4},
      '{OP_PUSH, 0,   16'h0011, 16'h0000, 4'd3},
      '{OP_PUSH, 0,   16'h0122, 16'h0000, 4'd10},
      '{OP_PUSH, 0,   16'h0233, 16'h0000, 4'd10},
      '{OP_RD,   CNT, 16'h0000, 16'h0003, 4'd3},  // R3
      '{OP_RD,   STA, 16'h0000, 16'h1121, 4'd4},  // R4 below threshold, R13, R10
      '{OP_PUSH, 0,   16'h0044, 16'h0000, 4'd4},
      '{OP_RD,   STA, 16'h0000, 16'h1123, 4'd4},  // R4 reaches 4
      '{OP_RD,   RXD, 16'h0000, 16'h0011, 4'd3},  // R3 order
      '{OP_RD,   STA, 16'h0000, 16'h1127, 4'd10}, // R10 head parity
      '{OP_WR,   STA, 16'h00FD, 16'h0000, 4'd6},
      '{OP_RD,   STA, 16'h0000, 16'h1125, 4'd6},  // R6 clear by zero
      '{OP_RD,   RXD, 16'h0000, 16'h0022, 4'd3},
      '{OP_RD,   STA, 16'h0000, 16'h0129, 4'd10}, // R10 head framing
      '{OP_RD,   RXD, 16'h0000, 16'h0033, 4'd3},
      '{OP_RD,   RXD, 16'h0000, 16'h0044, 4'd3},
      '{OP_RD,   CNT, 16'h0000, 16'h0000, 4'd3},
      '{OP_RD,   STA, 16'h0000, 16'h0021, 4'd13}, // R13 sticky data ready
      '{OP_WR,   STA, 16'h00FE, 16'h0000, 4'd13},
      '{OP_RD,   STA, 16'h0000, 16'h0020, 4'd13},
      '{OP_WR,   CTL, 16'h0030, 16'h0000, 4'd5},
      '{OP_WR,   TXD, 16'h00A5, 16'h0000, 4'd2},
      '{OP_WR,   TXD, 16'h005A, 16'h0000, 4'd2},
      '{OP_RD,   CNT, 16'h0000, 16'h0200, 4'd3},
      '{OP_WR,   STA, 16'h00DF, 16'h0000, 4'd5},
      '{OP_RD,   STA, 16'h0000, 16'h0000, 4'd5},  // R5 above threshold 1
      '{OP_TAKE, 0,   16'h0000, 16'h00A5, 4'd2},  // R2 order
      '{OP_RD,   STA, 16'h0000, 16'h0020, 4'd5},  // R5 at threshold 1
      '{OP_TAKE, 0,   16'h0000, 16'h005A, 4'd2},
      '{OP_DONE, 0,   16'h0000, 16'h0000, 4'd12},
      '{OP_RD,   STA, 16'h0000, 16'h0060, 4'd12}, // R12 transmit end
      '{OP_WR,   TXD, 16'h0077, 16'h0000, 4'd12},
      '{OP_RD,   STA, 16'h0000, 16'h0020, 4'd12}, // R12 cleared by write
      '{OP_TAKE, 0,   16'h0000, 16'h0077, 4'd2},
      '{OP_RD,   CNT, 16'h0000, 16'h0000, 4'd2},
      '{OP_WR,   CTL, 16'h0031, 16'h0000, 4'd8},
      '{OP_WR,   TXD, 16'h009C, 16'h0000, 4'd8},
      '{OP_PUSH, 0,   16'h0055, 16'h0000, 4'd8},
      '{OP_TAKE, 0,   16'h0000, 16'h009C, 4'd8},
      '{OP_RD,   CNT, 16'h0000, 16'h0001, 4'd8},  // R8 one looped byte only
      '{OP_RD,   RXD, 16'h0000, 16'h009C, 4'd8},
      '{OP_RD,   CNT, 16'h0000, 16'h0000, 4'd8},
      '{OP_WR,   CTL, 16'h0000, 16'h0000, 4'd11},
      '{OP_PUSH, 0,   16'h0400, 16'h0000, 4'd11},
      '{OP_RD,   STA, 16'h0000, 16'h0033, 4'd11}, // R11 break
      '{OP_WR,   STA, 16'h00EF, 16'h0000, 4'd6},
      '{OP_RD,   STA, 16'h0000, 16'h0023, 4'd6},  // R6 only break cleared
      '{OP_RD,   RXD, 16'h0000, 16'h0000, 4'd3}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        txq_valid;
   logic [7:0]  txq_data;
   logic        txq_take = 1'b0, shift_done = 1'b0;
   logic        rxq_push = 1'b0;
   logic [7:0]  rxq_data = '0;
   logic        rxq_perr = 1'b0, rxq_ferr = 1'b0, rxq_brk = 1'b0;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   serbuf_core uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txq_valid(txq_valid), .txq_data(txq_data),
      .txq_take(txq_take), .shift_done(shift_done), .rxq_push(rxq_push), .rxq_data(rxq_data),
      .rxq_perr(rxq_perr), .rxq_ferr(rxq_ferr), .rxq_brk(rxq_brk)
   );

   task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL R%0d: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic op(input logic [2:0] kind, input logic [2:0] a, input logic [15:0] d,
                     input logic [15:0] exp, input int req);
      @(negedge clk);
      bus_addr = a;
      case (kind)
         OP_RD: begin
            bus_rd = 1'b1;
            #2 check(req, bus_rdata, exp);
         end
         OP_WR: begin
            bus_wr = 1'b1;
            bus_wdata = d;
         end
         OP_PUSH: begin
            rxq_push = 1'b1;
            rxq_data = d[7:0];
            rxq_perr = d[8];
            rxq_ferr = d[9];
            rxq_brk  = d[10];
         end
         OP_TAKE: begin
            txq_take = 1'b1;
            #2 check(req, {7'd0, txq_valid, txq_data}, {8'h01, exp[7:0]});
         end
         default: shift_done = 1'b1;
      endcase
      @(negedge clk);
      bus_rd = 1'b0; bus_wr = 1'b0; rxq_push = 1'b0; txq_take = 1'b0; shift_done = 1'b0;
      rxq_perr = 1'b0; rxq_ferr = 1'b0; rxq_brk = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      #1 check(1, bus_rdata, 16'h0000); // R1 status bus value while in reset (addr 0)
      repeat (3) @(negedge clk);
      bus_addr = STA;
      #2 check(1, bus_rdata, 16'h0000); // R1 flags clear during reset
      rst_n = 1'b1;
      @(posedge clk);

      for (int i = 0; i < NV; i++)
         op(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].exp, int'(VEC[i].req));

      // R9 and R10: overflow the receive FIFO with parity-marked bytes
      op(OP_WR, STA, 16'h0000, 0, 6);
      for (int i = 0; i < 17; i++) op(OP_PUSH, 0, 16'h0100 | 16'(i), 0, 9);
      op(OP_RD, CNT, 0, 16'h0010, 9);
      op(OP_RD, STA, 0, 16'hF0A7, 9);   // R9 error flag, R10 saturated count
      for (int i = 0; i < 16; i++) op(OP_RD, RXD, 0, 16'(i), 3);
      op(OP_RD, CNT, 0, 16'h0000, 3);

      // R7: receive reset empties and holds
      for (int i = 0; i < 3; i++) op(OP_PUSH, 0, 16'h0060, 0, 7);
      op(OP_WR, CTL, 16'h0002, 0, 7);
      op(OP_RD, CNT, 0, 16'h0000, 7);
      op(OP_PUSH, 0, 16'h0012, 0, 7);
      op(OP_RD, CNT, 0, 16'h0000, 7);

      // R4: thresholds 8 and 14
      op(OP_WR, CTL, 16'h0080, 0, 4);
      op(OP_WR, STA, 16'h0000, 0, 4);
      for (int i = 0; i < 7; i++) op(OP_PUSH, 0, 16'(i), 0, 4);
      op(OP_RD, STA, 0, 16'h0021, 4);
      op(OP_PUSH, 0, 16'h0007, 0, 4);
      op(OP_RD, STA, 0, 16'h0023, 4);
      op(OP_WR, CTL, 16'h00C0, 0, 4);
      for (int i = 0; i < 5; i++) op(OP_PUSH, 0, 16'(i), 0, 4);
      op(OP_WR, STA, 16'h00FD, 0, 4);
      op(OP_RD, STA, 0, 16'h0021, 4);
      op(OP_PUSH, 0, 16'h0000, 0, 4);
      op(OP_RD, STA, 0, 16'h0023, 4);
      op(OP_WR, CTL, 16'h0002, 0, 7);
      op(OP_WR, CTL, 16'h0000, 0, 7);

      // R2 and R5: transmit overflow, thresholds 8 and 4
      op(OP_WR, STA, 16'h0000, 0, 6);
      for (int i = 0; i < 17; i++) op(OP_WR, TXD, 16'h0040 + 16'(i), 0, 2);
      op(OP_RD, CNT, 0, 16'h1000, 2);
      op(OP_WR, STA, 16'h0000, 0, 5);
      op(OP_RD, STA, 0, 16'h0000, 5);
      for (int i = 0; i < 8; i++) op(OP_TAKE, 0, 0, 16'h0040 + 16'(i), 2);
      op(OP_RD, STA, 0, 16'h0020, 5);
      op(OP_WR, CTL, 16'h0010, 0, 5);
      op(OP_WR, STA, 16'h0000, 0, 5);
      op(OP_RD, STA, 0, 16'h0000, 5);
      for (int i = 0; i < 4; i++) op(OP_TAKE, 0, 0, 16'h0048 + 16'(i), 2);
      op(OP_RD, STA, 0, 16'h0020, 5);
      op(OP_WR, CTL, 16'h0004, 0, 7);
      op(OP_RD, CNT, 0, 16'h0000, 7);  // R7 transmit reset
      op(OP_WR, TXD, 16'h00EE, 0, 7);
      op(OP_RD, CNT, 0, 16'h0000, 7);

      // R1: reset in mid run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      op(OP_RD, CTL, 0, 16'h0000, 1);
      op(OP_RD, STA, 0, 16'h0020, 1);
      op(OP_RD, CNT, 0, 16'h0000, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule